// File: doc/BRIEF.md
# Multi-Channel Tamper Event Controller

This block gathers tamper detections from four external channels and from one internal event input. The external detections arrive as one-cycle pulses that the input conditioners have already qualified. Each external channel has a two-bit action field. A zero action turns the channel off. Any other value lets a detection on that channel record itself. The internal event input has its own enable bit.

Every source that fires sets a sticky status bit of its own. Software reads these bits to find which source caused the event. It clears a bit by writing a one to that bit position. All status bits feed one shared interrupt line, which a global interrupt enable gates.

Software reaches the block through a small register port with two registers. The control register sits at address 0. It holds the four action fields, the event enable and the interrupt enable. The status register sits at address 1 and is cleared by writing ones. Reads are combinational from the address.

Top module: `tamper_evctl`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 and `irq_o` is low.
- R2: In the control register, channel i's action field is at bits [2i+1:2i], the event enable is at bit 8 and the interrupt enable is at bit 9. A write to address 0 reads back exactly as written from the following cycle.
- R3: A `det_i[i]` pulse on a channel whose action field is nonzero sets status bit i at the next clock edge.
- R4: A `det_i[i]` pulse on a channel whose action field is 0 is ignored, and status bit i stays 0.
- R5: A set status bit stays set after its source pulse ends, until software clears it.
- R6: A write to address 1 clears every status bit whose data bit is 1 and leaves the other status bits unchanged.
- R7: A detection and a clear that hit the same status bit in the same cycle leave the bit set.
- R8: An `evt_i` pulse sets status bit 4 only when the event enable (control bit 8) is 1. When the event enable is 0, the pulse is ignored.
- R9: `irq_o` is high exactly when the interrupt enable (control bit 9) is 1 and at least one status bit is set. It follows a change in status or enable in the same cycle that the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | 4 | Qualified detection pulses, one per external channel |
| evt_i | input | 1 | Tamper pulse from the internal event system |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 is control, 1 is status |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Shared tamper interrupt request |

## Verification
Every register write and every detection or event pulse takes effect at the first clock edge after it is driven. The read data and `irq_o` follow the new register state within that same cycle, because both are combinational.

The bench drives each stimulus for exactly one edge, starting just after a rising edge. It samples one time step after the next rising edge, which makes one register stage the whole expected latency.

The same-cycle race between a detection and a clear is driven in a single cycle. The sticky tests and the ignored-input tests wait several further cycles before they sample.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_STAT = 1;
endpackage

// File: rtl/tamper_cfg.sv
module tamper_cfg #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ACT_W  = 2,
    parameter int unsigned CFG_W  = NUM_CH*ACT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [CFG_W-1:0]        wdata_i,
    output logic [NUM_CH*ACT_W-1:0] act_o,
    output logic                    ev_en_o,
    output logic                    irq_en_o
);
    localparam int unsigned ACT_BITS = NUM_CH*ACT_W;

    typedef struct packed {
        logic                irq_en;
        logic                ev_en;
        logic [ACT_BITS-1:0] act;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d = cfg_t'(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act_o    = cfg_q.act;
    assign ev_en_o  = cfg_q.ev_en;
    assign irq_en_o = cfg_q.irq_en;
endmodule

// File: rtl/tamper_status.sv
module tamper_status #(
    parameter int unsigned ST_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_i,
    input  logic [ST_W-1:0] clr_i,
    output logic [ST_W-1:0] status_o
);
    typedef struct packed {
        logic [ST_W-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clearing happens first, so a detection in the same cycle keeps its bit set.
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.flags;
endmodule

// File: rtl/tamper_evctl.sv
module tamper_evctl
    import tamper_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ACT_W  = 2,
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned DATA_W = NUM_CH*ACT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] det_i,
    input  logic              evt_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int unsigned ST_W     = NUM_CH + 1;
    localparam int unsigned ACT_BITS = NUM_CH*ACT_W;

    logic [ACT_BITS-1:0] act;
    logic                ev_en;
    logic                irq_en;
    logic [NUM_CH-1:0]   en_mask;
    logic [ST_W-1:0]     set_mask;
    logic [ST_W-1:0]     clr_mask;
    logic [ST_W-1:0]     status;
    logic                sel_ctrl;
    logic                sel_stat;

    assign sel_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
    assign sel_stat = (reg_addr == ADDR_W'(ADDR_STAT));

    tamper_cfg #(
        .NUM_CH (NUM_CH),
        .ACT_W  (ACT_W),
        .CFG_W  (DATA_W)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_we && sel_ctrl),
        .wdata_i  (reg_wdata),
        .act_o    (act),
        .ev_en_o  (ev_en),
        .irq_en_o (irq_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
        assign en_mask[ch]  = |act[ch*ACT_W +: ACT_W];
        assign set_mask[ch] = det_i[ch] & en_mask[ch];
    end
    assign set_mask[NUM_CH] = evt_i & ev_en;

    assign clr_mask = (reg_we && sel_stat) ? reg_wdata[ST_W-1:0] : '0;

    tamper_status #(
        .ST_W (ST_W)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_mask),
        .clr_i    (clr_mask),
        .status_o (status)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata = {irq_en, ev_en, act};
        end else if (sel_stat) begin
            reg_rdata[ST_W-1:0] = status;
        end
    end

    assign irq_o = irq_en & (|status);
endmodule

// File: rtl/tamper_evctl_chk.sv
module tamper_evctl_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] det_i,
    input logic              evt_i,
    input logic [NUM_CH-1:0] en_mask,
    input logic              ev_en,
    input logic              irq_en,
    input logic [NUM_CH:0]   clr_mask,
    input logic [NUM_CH:0]   status,
    input logic              irq_o
);
    assert_det_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[NUM_CH-1:0] & $past(det_i & en_mask)) == $past(det_i & en_mask)));

    assert_off_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((status[NUM_CH-1:0] & ~$past(status[NUM_CH-1:0])) & ~$past(det_i & en_mask)) == '0));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

    assert_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status & ~$past(clr_mask)) == '0));

    assert_evt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[NUM_CH]) |-> $past(evt_i && ev_en)));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en && (status != '0)));

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (status != '0)) |-> irq_o);
endmodule

bind tamper_evctl tamper_evctl_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_i    (det_i),
    .evt_i    (evt_i),
    .en_mask  (en_mask),
    .ev_en    (ev_en),
    .irq_en   (irq_en),
    .clr_mask (clr_mask),
    .status   (status),
    .irq_o    (irq_o)
);

// File: tb/test_tamper_evctl.sv
`timescale 1ns/1ps
module test_tamper_evctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] det_i = '0;
    logic       evt_i = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       irq_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tamper_evctl i_tamper_evctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_i     (det_i),
        .evt_i     (evt_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [9:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [9:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] d, input logic e);
        det_i = d; evt_i = e;
        step();
        det_i = '0; evt_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [9:0] v;
        rd(1'b0, v); check("R1 ctrl", v, 10'h000);
        rd(1'b1, v); check("R1 status", v, 10'h000);
        check("R1 irq", {9'b0, irq_o}, 10'h000);
    endtask

    task automatic t_readback();
        logic [9:0] v;
        wr(1'b0, 10'h0E4);
        rd(1'b0, v); check("R2 ctrl readback", v, 10'h0E4);
    endtask

    task automatic t_gating();
        logic [9:0] v;
        pulse(4'hF, 1'b0);
        rd(1'b1, v); check("R3 R4 enabled set, ch0 off ignored", v, 10'h00E);
    endtask

    task automatic t_sticky();
        logic [9:0] v;
        repeat (3) step();
        rd(1'b1, v); check("R5 sticky", v, 10'h00E);
    endtask

    task automatic t_clear();
        logic [9:0] v;
        wr(1'b1, 10'h004);
        rd(1'b1, v); check("R6 partial clear", v, 10'h00A);
        wr(1'b1, 10'h00A);
        rd(1'b1, v); check("R6 full clear", v, 10'h000);
    endtask

    task automatic t_race();
        logic [9:0] v;
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 10'h006; det_i = 4'h2;
        step();
        reg_we = 1'b0; reg_wdata = '0; det_i = '0;
        rd(1'b1, v); check("R7 detect beats clear", v, 10'h002);
        wr(1'b1, 10'h01F);
        rd(1'b1, v); check("R6 clear after race", v, 10'h000);
    endtask

    task automatic t_event();
        logic [9:0] v;
        pulse(4'h0, 1'b1);
        repeat (2) step();
        rd(1'b1, v); check("R8 event disabled ignored", v, 10'h000);
        wr(1'b0, 10'h1E4);
        pulse(4'h0, 1'b1);
        rd(1'b1, v); check("R8 event enabled sets bit4", v, 10'h010);
    endtask

    task automatic t_irq();
        logic [9:0] v;
        check("R9 irq off while disabled", {9'b0, irq_o}, 10'h000);
        wr(1'b0, 10'h3E4);
        check("R9 irq on after enable", {9'b0, irq_o}, 10'h001);
        wr(1'b1, 10'h010);
        check("R9 irq drops when status clear", {9'b0, irq_o}, 10'h000);
        pulse(4'h8, 1'b0);
        check("R9 irq on channel 3 detect", {9'b0, irq_o}, 10'h001);
        rd(1'b1, v); check("R3 channel 3 status", v, 10'h008);
        wr(1'b0, 10'h1E4);
        check("R9 irq masked by enable", {9'b0, irq_o}, 10'h000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_readback();
        t_gating();
        t_sticky();
        t_clear();
        t_race();
        t_event();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule